// File: doc/BRIEF.md
# Carry-Chained Integer ALU

This block is the arithmetic and logic stage of a small 32-bit microcontroller core. It takes a first register value and a second operand, and it returns a result and the next value of the carry flag. The second operand is either the second register value or a zero-extended 8-bit immediate. An opcode picks the operation, a destination-width code trims the result, and the stored carry flag comes in from outside. The surrounding core owns the register file, the decoder and the carry register. This block only presents the carry value that the core should store next.

The operations are as follows:
- add and subtract, each with and without the incoming carry;
- reverse-order subtract, again with and without carry;
- logical shifts in both directions;
- AND, OR, XOR and NOT;
- unsigned minimum and maximum;
- clearing or setting a single bit.

Every add or subtract variant takes its carry from the full-precision result, at the bit just above the selected destination width. A subtract therefore reports a borrow. Shift amounts and bit indices use only the low five bits of the second operand. The result is captured in one output register stage, so it is due one clock after its inputs.

Top module: `alu_core`

## Requirements
- R1: When `use_imm` is 1, the second operand is `imm8` zero-extended to 32 bits and `src_b` is ignored. When `use_imm` is 0, the second operand is `src_b`.
- R2: Opcode 0 computes a + b, and opcode 1 computes a + b + carry_in.
- R3: Opcode 2 computes a - b, and opcode 3 computes a - b - carry_in.
- R4: Opcode 4 computes b - a, and opcode 5 computes b - a - carry_in.
- R5: For opcodes 0 to 5, `carry_out` is bit W of the untruncated result, where W is the destination width in bits. The operands keep all 32 bits when this is computed, and on a subtract this bit is the borrow.
- R6: Opcode 6 shifts a left and opcode 7 shifts a right, both logically. The shift amount is the low 5 bits of b.
- R7: Opcode 14 clears, and opcode 15 sets, the bit of a whose index is the low 5 bits of b.
- R8: Opcodes 8, 9 and 10 give a AND b, a OR b and a XOR b. Opcode 11 gives NOT a, and b has no effect on it.
- R9: Opcode 12 gives the unsigned minimum of a and b, and opcode 13 gives the unsigned maximum.
- R10: For opcodes 6 to 15, `carry_out` equals `carry_in`.
- R11: `dst_w` code 0 keeps 8 result bits, code 1 keeps 16, and codes 2 and 3 keep 32. All bits above the kept width read 0.
- R12: Opcodes 16 to 31 are illegal. They give `result` 0 and `illegal_op` 1, and `carry_out` equals `carry_in`. Every legal opcode gives `illegal_op` 0.
- R13: The outputs are registered and show the response to the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, `result`, `carry_out` and `illegal_op` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 5 | Operation select |
| use_imm | input | 1 | Selects the immediate as the second operand |
| imm8 | input | 8 | Immediate operand |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| dst_w | input | 2 | Destination width code |
| carry_in | input | 1 | Stored carry flag |
| result | output | 32 | Truncated result |
| carry_out | output | 1 | Next carry flag value |
| illegal_op | output | 1 | Unsupported opcode indicator |

## Verification
Every result, every carry and the illegal flag are due exactly one rising edge after the inputs are applied. The bench changes the inputs on a falling edge and lets one rising edge pass. On the following falling edge it compares all three outputs with its reference model, so a value is never read in the cycle where it changes. The assertions use the same one-cycle offset, relating each output to the value that `$past` gives for the inputs. They check only after a cycle in which reset was not asserted.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int XLEN   = 32;
  localparam int IMM_W  = 8;
  localparam int OP_W   = 5;
  localparam int WSEL_W = 2;
  localparam int W_BYTE = 8;
  localparam int W_HALF = 16;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_RSB  = 5'd4,
    OP_RSC  = 5'd5,
    OP_SHL  = 5'd6,
    OP_SHR  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_NOT  = 5'd11,
    OP_MIN  = 5'd12,
    OP_MAX  = 5'd13,
    OP_BCLR = 5'd14,
    OP_BSET = 5'd15
  } alu_op_e;

  typedef enum logic [WSEL_W-1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2,
    WSEL_XX = 2'd3
  } wsel_e;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DATA_W = alu_pkg::XLEN,
  parameter int IMM_W  = alu_pkg::IMM_W
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] op_b
);
  localparam int PAD_W = DATA_W - IMM_W;

  assign op_b = use_imm ? {{PAD_W{1'b0}}, imm} : reg_b;
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = alu_pkg::XLEN
) (
  input  alu_pkg::alu_op_e  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W:0]   full,
  output logic              is_arith
);
  import alu_pkg::*;

  localparam int FW = DATA_W + 1;

  // Full-precision add or subtract with an optional carry or borrow term.
  function automatic logic [FW-1:0] addsub(
    input logic [FW-1:0] x,
    input logic [FW-1:0] y,
    input logic [FW-1:0] c,
    input logic          do_sub
  );
    if (do_sub) return x - y - c;
    else        return x + y + c;
  endfunction

  logic [FW-1:0] ax, bx, cx;

  assign ax = {1'b0, a};
  assign bx = {1'b0, b};
  assign cx = {{DATA_W{1'b0}}, cin};

  always_comb begin
    full     = '0;
    is_arith = 1'b1;
    unique case (op)
      OP_ADD:  full = addsub(ax, bx, '0, 1'b0);
      OP_ADC:  full = addsub(ax, bx, cx, 1'b0);
      OP_SUB:  full = addsub(ax, bx, '0, 1'b1);
      OP_SBC:  full = addsub(ax, bx, cx, 1'b1);
      OP_RSB:  full = addsub(bx, ax, '0, 1'b1);
      OP_RSC:  full = addsub(bx, ax, cx, 1'b1);
      default: is_arith = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = alu_pkg::XLEN
) (
  input  alu_pkg::alu_op_e  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  import alu_pkg::*;

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] bit_sel;
  logic              a_lt_b;

  assign shamt   = b[SH_W-1:0];
  assign bit_sel = {{(DATA_W-1){1'b0}}, 1'b1} << shamt;
  assign a_lt_b  = a < b;

  always_comb begin
    res = '0;
    case (op)
      OP_SHL:  res = a << shamt;
      OP_SHR:  res = a >> shamt;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_MIN:  res = a_lt_b ? a : b;
      OP_MAX:  res = a_lt_b ? b : a;
      OP_BCLR: res = a & ~bit_sel;
      OP_BSET: res = a | bit_sel;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int DATA_W = alu_pkg::XLEN,
  parameter int IMM_W  = alu_pkg::IMM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [alu_pkg::OP_W-1:0]  op_code,
  input  logic                      use_imm,
  input  logic [IMM_W-1:0]          imm8,
  input  logic [DATA_W-1:0]         src_a,
  input  logic [DATA_W-1:0]         src_b,
  input  logic [alu_pkg::WSEL_W-1:0] dst_w,
  input  logic                      carry_in,
  output logic [DATA_W-1:0]         result,
  output logic                      carry_out,
  output logic                      illegal_op
);
  import alu_pkg::*;

  localparam int CIDX_W  = $clog2(DATA_W + 1);
  localparam int N_LEGAL = 16;

  // Named internal events, also watched by the checker.
  logic [DATA_W-1:0] op_b;
  logic [DATA_W:0]   arith_full;
  logic [DATA_W-1:0] logic_res;
  logic              is_arith;
  logic              is_illegal;
  logic [DATA_W-1:0] width_mask;
  logic [CIDX_W-1:0] carry_idx;
  alu_op_e           op;

  logic [DATA_W-1:0] next_res;
  logic              next_carry;

  assign op         = alu_op_e'(op_code);
  assign is_illegal = int'(op_code) >= N_LEGAL;

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_imm (use_imm),
    .imm     (imm8),
    .reg_b   (src_b),
    .op_b    (op_b)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op       (op),
    .a        (src_a),
    .b        (op_b),
    .cin      (carry_in),
    .full     (arith_full),
    .is_arith (is_arith)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op  (op),
    .a   (src_a),
    .b   (op_b),
    .res (logic_res)
  );

  always_comb begin
    case (wsel_e'(dst_w))
      WSEL_8: begin
        width_mask = {{(DATA_W-W_BYTE){1'b0}}, {W_BYTE{1'b1}}};
        carry_idx  = CIDX_W'(W_BYTE);
      end
      WSEL_16: begin
        width_mask = {{(DATA_W-W_HALF){1'b0}}, {W_HALF{1'b1}}};
        carry_idx  = CIDX_W'(W_HALF);
      end
      default: begin
        width_mask = {DATA_W{1'b1}};
        carry_idx  = CIDX_W'(DATA_W);
      end
    endcase
  end

  always_comb begin
    if (is_illegal) begin
      next_res   = '0;
      next_carry = carry_in;
    end else if (is_arith) begin
      next_res   = arith_full[DATA_W-1:0] & width_mask;
      next_carry = arith_full[carry_idx];
    end else begin
      next_res   = logic_res & width_mask;
      next_carry = carry_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      carry_out  <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      result     <= next_res;
      carry_out  <= next_carry;
      illegal_op <= is_illegal;
    end
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DATA_W = alu_pkg::XLEN
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [alu_pkg::OP_W-1:0]   op_code,
  input logic [alu_pkg::WSEL_W-1:0] dst_w,
  input logic                       carry_in,
  input logic [DATA_W-1:0]          src_a,
  input logic [DATA_W-1:0]          op_b,
  input logic [DATA_W-1:0]          result,
  input logic                       carry_out,
  input logic                       illegal_op
);
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_code) >= 5'd16 |-> illegal_op && result == '0 && carry_out == $past(carry_in)); // R12

  AST_LEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_code) < 5'd16 |-> !illegal_op); // R12

  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_code) >= 5'd6 && $past(op_code) < 5'd16 |-> carry_out == $past(carry_in)); // R10

  AST_BYTE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dst_w) == 2'd0 |-> result[DATA_W-1:8] == '0); // R11

  AST_HALF_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dst_w) == 2'd1 |-> result[DATA_W-1:16] == '0); // R11

  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_code) == 5'd12 && $past(dst_w) >= 2'd2
    |-> result <= $past(src_a) && result <= $past(op_b)); // R9

  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_code) == 5'd13 && $past(dst_w) >= 2'd2
    |-> result >= $past(src_a) && result >= $past(op_b)); // R9
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_code    (op_code),
  .dst_w      (dst_w),
  .carry_in   (carry_in),
  .src_a      (src_a),
  .op_b       (op_b),
  .result     (result),
  .carry_out  (carry_out),
  .illegal_op (illegal_op)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_code = '0;
  logic        use_imm = 1'b0;
  logic [7:0]  imm8 = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [1:0]  dst_w = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .use_imm(use_imm),
    .imm8(imm8), .src_a(src_a), .src_b(src_b), .dst_w(dst_w),
    .carry_in(carry_in), .result(result), .carry_out(carry_out),
    .illegal_op(illegal_op)
  );

  function automatic string tag_of(input logic [4:0] op);
    if (op <= 1)       return "R2";
    else if (op <= 3)  return "R3";
    else if (op <= 5)  return "R4";
    else if (op <= 7)  return "R6";
    else if (op <= 11) return "R8";
    else if (op <= 13) return "R9";
    else if (op <= 15) return "R7";
    else               return "R12";
  endfunction

  // Behavioural reference built from the requirement text with 64-bit integers.
  task automatic model(output logic [31:0] r, output logic c, output logic ill);
    longint a, b, cy, full, w;
    a    = longint'(src_a);
    b    = use_imm ? longint'(imm8) : longint'(src_b);
    cy   = longint'(carry_in);
    w    = (dst_w == 2'd0) ? 8 : (dst_w == 2'd1) ? 16 : 32;
    ill  = 1'b0;
    c    = carry_in;
    full = 0;
    case (op_code)
      5'd0:  full = a + b;
      5'd1:  full = a + b + cy;
      5'd2:  full = a - b;
      5'd3:  full = a - b - cy;
      5'd4:  full = b - a;
      5'd5:  full = b - a - cy;
      5'd6:  full = (a << (b % 32)) % (64'd1 << 32);
      5'd7:  full = a >> (b % 32);
      5'd8:  full = a & b;
      5'd9:  full = a | b;
      5'd10: full = a ^ b;
      5'd11: full = 64'hFFFF_FFFF - a;
      5'd12: full = (a < b) ? a : b;
      5'd13: full = (a > b) ? a : b;
      5'd14: full = a & (64'hFFFF_FFFF - (64'd1 << (b % 32)));
      5'd15: full = a | (64'd1 << (b % 32));
      default: begin full = 0; ill = 1'b1; end
    endcase
    if (op_code <= 5'd5) c = 1'((full >> w) & 1);
    r = 32'(full & ((64'd1 << w) - 1));
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ec, input logic ei);
    checks++;
    if (result !== er || carry_out !== ec || illegal_op !== ei) begin
      errors++;
      $display("FAIL %s op=%0d: actual res=%h c=%b ill=%b expected res=%h c=%b ill=%b",
               tag, op_code, result, carry_out, illegal_op, er, ec, ei);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, compare at the next falling edge.
  task automatic apply(input string tag, input logic [4:0] op, input logic ui,
                       input logic [7:0] im, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] w, input logic ci);
    logic [31:0] er;
    logic ec, ei;
    op_code = op; use_imm = ui; imm8 = im; src_a = a; src_b = b; dst_w = w; carry_in = ci;
    model(er, ec, ei);
    @(posedge clk);
    @(negedge clk);
    check(tag, er, ec, ei);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13", 32'h0, 1'b0, 1'b0);                      // reset state
    rst_n = 1'b1;
    @(negedge clk);
    // R1: immediate replaces src_b, zero-extended
    apply("R1", 5'd0, 1'b1, 8'hFF, 32'h1, 32'hDEAD_BEEF, 2'd2, 1'b0);
    apply("R1", 5'd0, 1'b0, 8'hFF, 32'h1, 32'h10, 2'd2, 1'b0);
    // R2 / R5: add carries
    apply("R5", 5'd0, 1'b0, 8'h0, 32'hFFFF_FFFF, 32'h1, 2'd2, 1'b0);
    apply("R2", 5'd1, 1'b0, 8'h0, 32'h10, 32'h20, 2'd2, 1'b1);
    apply("R5", 5'd0, 1'b0, 8'h0, 32'h0000_00FF, 32'h1, 2'd0, 1'b0);
    apply("R5", 5'd0, 1'b0, 8'h0, 32'h0000_01FF, 32'h1, 2'd0, 1'b0);
    // R3 / R4 / R5: borrows
    apply("R3", 5'd2, 1'b0, 8'h0, 32'h0, 32'h1, 2'd2, 1'b0);
    apply("R3", 5'd3, 1'b0, 8'h0, 32'h5, 32'h5, 2'd1, 1'b1);
    apply("R4", 5'd4, 1'b1, 8'h03, 32'h5, 32'h0, 2'd2, 1'b0);
    apply("R4", 5'd5, 1'b0, 8'h0, 32'h1, 32'h9, 2'd2, 1'b1);
    // R6 / R7: low five bits only
    apply("R6", 5'd6, 1'b0, 8'h0, 32'h8000_0001, 32'd33, 2'd2, 1'b1);
    apply("R6", 5'd7, 1'b1, 8'd36, 32'hF000_0000, 32'h0, 2'd2, 1'b0);
    apply("R7", 5'd15, 1'b1, 8'd37, 32'h0, 32'h0, 2'd2, 1'b0);
    apply("R7", 5'd14, 1'b0, 8'h0, 32'hFFFF_FFFF, 32'd63, 2'd2, 1'b1);
    // R8: NOT ignores b
    apply("R8", 5'd11, 1'b0, 8'h0, 32'h1234_5678, 32'h0, 2'd2, 1'b0);
    apply("R8", 5'd11, 1'b0, 8'h0, 32'h1234_5678, 32'hFFFF_FFFF, 2'd2, 1'b0);
    // R9: unsigned compare with top bit set
    apply("R9", 5'd12, 1'b0, 8'h0, 32'h8000_0000, 32'h7FFF_FFFF, 2'd2, 1'b0);
    apply("R9", 5'd13, 1'b0, 8'h0, 32'h8000_0000, 32'h7FFF_FFFF, 2'd2, 1'b0);
    // R10: carry passes through logic ops
    apply("R10", 5'd8, 1'b0, 8'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b1);
    // R11: widths, code 3 behaves as 32
    apply("R11", 5'd9, 1'b0, 8'h0, 32'hABCD_1234, 32'h0, 2'd1, 1'b0);
    apply("R11", 5'd9, 1'b0, 8'h0, 32'hABCD_1234, 32'h0, 2'd3, 1'b0);
    // R12: illegal opcodes
    apply("R12", 5'd20, 1'b0, 8'h0, 32'hFFFF_FFFF, 32'h1, 2'd2, 1'b1);
    apply("R12", 5'd31, 1'b0, 8'h0, 32'h1, 32'h1, 2'd2, 1'b0);
    // R13: reset mid-run clears outputs
    apply("R13", 5'd20, 1'b0, 8'h0, 32'h1, 32'h1, 2'd2, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R13", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // Broad coverage against the reference model, one compare per clock
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 19));
      apply(tag_of(op), op, 1'($urandom), 8'($urandom), $urandom,
            (i % 4 == 0) ? 32'($urandom_range(0, 70)) : $urandom,
            2'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule